// File: doc/BRIEF.md
# Write-Protected Real-Time Clock Register Bank

This block holds the byte registers of a real-time clock: one block of current-time bytes, two alarm blocks with the same layout, two trim registers and a status register. A host reaches it through a plain parallel port. It loads a 16-bit pointer from two address bytes, writes the byte at the pointer with a write strobe, and reads with a read strobe. After each read byte the pointer steps forward by one, so a burst of reads walks through consecutive registers. The calendar counter sits outside this block. Each accepted write into the time block is passed to the counter as a one-cycle load pulse that carries the byte index and its value.

Writes to the time, alarm and trim registers are blocked until the status register has been unlocked in two ordered steps. A small state machine follows the unlock sequence. Its states are LK_LOCKED (no enables), LK_LATCH (write-enable latch only) and LK_OPEN (latch plus register write enable). All of its transitions happen on a write to the status register:
- From any state, 0x02 moves to LK_LATCH.
- From LK_LATCH or LK_OPEN, 0x06 moves to LK_OPEN.
- From LK_LOCKED, 0x06 stays in LK_LOCKED.
- From any state, 0x00 or any other value moves to LK_LOCKED.

A clock-failure flag is set at reset. It stays set until the first accepted write into the time block.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the status register (0x3F) reads 0x01 (bit 0 = clock-failure flag, bit 1 = write-enable latch, bit 2 = register write enable), and every storage register reads 0x00.
- R2: Writing 0x02 and then 0x06 to 0x3F unlocks the bank. After the first step status reads 0x03, after the second it reads 0x07, and writes to protected registers then take effect.
- R3: While the bank is not fully unlocked, writes to the time (0x30-0x37), alarm (0x00-0x0F) and trim (0x12, 0x13) registers leave them unchanged.
- R4: Writing 0x06 to 0x3F while locked, with no 0x02 before it, leaves the bank locked. Status reads 0x01 and protected writes are still ignored.
- R5: Writing 0x00, or any value other than 0x02 and 0x06, to 0x3F returns the bank to the locked state, and later protected writes are ignored.
- R6: A read returns, one cycle after the read strobe, the byte at the pointer, and the pointer then steps by one. Eight consecutive reads from 0x30 return the time block in order: seconds, minutes, hours, day, month, year, weekday, century.
- R7: A pointer whose upper byte is nonzero, or whose lower byte names no register, reads 0x00, and writes to it have no effect.
- R8: Reserved bits read as zero: status bits 7-3, digital trim (0x13) bits 7-3, analog trim (0x12) bits 7-6, and all of register 0x10.
- R9: The clock-failure flag is cleared by an accepted write into the time block and by nothing else. Alarm writes and blocked time writes leave it set.
- R10: An accepted time write raises load_o for exactly one cycle, in the cycle after the write strobe. It carries the byte index (address minus 0x30) and the written value. Alarm, trim and blocked writes raise no pulse.
- R11: Alarm set 0 occupies 0x00-0x07 and alarm set 1 occupies 0x08-0x0F, each in the time-block byte order, and each byte reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_set_i | input | 1 | Load the pointer from the two address bytes |
| ptr_hi_i | input | 8 | Upper address byte (must be zero to reach a register) |
| ptr_lo_i | input | 8 | Lower address byte, selects the register |
| wr_en_i | input | 1 | Write strobe for the byte at the pointer |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; pointer advances afterwards |
| rd_data_o | output | 8 | Read data, valid the cycle after rd_en_i |
| load_o | output | 1 | One-cycle load pulse toward the calendar counter |
| load_idx_o | output | 3 | Time-block byte index of the load |
| load_byte_o | output | 8 | Byte value of the load |

## Verification
The bench probes the unlock ordering. A design that accepts 0x06 without a prior 0x02 would let a time byte through and clear the failure flag. A design that ignores a relock would keep overwriting the time block after 0x00. It checks that alarm writes neither clear the failure flag nor pulse the load port, which a design that decodes the time range too widely would get wrong. It also checks that a nonzero upper address byte hides the registers, which a design that drops that byte would break by aliasing 0x0130 onto 0x30. Reserved trim and status bits are written as ones and must read back as zero, and a burst read must step through eight bytes in order without repeating the first one.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_LATCH  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_e;

    localparam logic [7:0] STATUS_ADDR = 8'h3F;
    localparam logic [7:0] DTRIM_ADDR  = 8'h13;
    localparam logic [7:0] ATRIM_ADDR  = 8'h12;
    localparam logic [7:0] KEY_LATCH   = 8'h02;
    localparam logic [7:0] KEY_OPEN    = 8'h06;
endpackage

// File: rtl/wpr_lock_fsm.sv
module wpr_lock_fsm
    import wpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic [7:0] st_data,
    output lock_e      state,
    output logic       wel,
    output logic       rwel
);
    lock_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_LOCKED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (st_wr) begin
            unique case (state)
                LK_LOCKED: nxt = (st_data == KEY_LATCH) ? LK_LATCH : LK_LOCKED;
                LK_LATCH,
                LK_OPEN:   nxt = (st_data == KEY_LATCH) ? LK_LATCH :
                                 (st_data == KEY_OPEN)  ? LK_OPEN  : LK_LOCKED;
                default:   nxt = LK_LOCKED;
            endcase
        end
    end

    always_comb begin
        wel  = (state != LK_LOCKED);
        rwel = (state == LK_OPEN);
    end
endmodule

// File: rtl/wpr_reg_store.sv
module wpr_reg_store
    import wpr_pkg::*;
#(
    parameter int         BLK_BYTES  = 8,
    parameter int         ALARM_SETS = 2,
    parameter logic [7:0] TIME_BASE  = 8'h30
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   waddr,
    input  logic [7:0]                   wdata,
    input  logic [7:0]                   raddr,
    output logic [7:0]                   rdata,
    output logic                         w_time_hit,
    output logic [$clog2(BLK_BYTES)-1:0] w_idx
);
    localparam int         ALM_BYTES = BLK_BYTES * ALARM_SETS;
    localparam int         IW        = $clog2(BLK_BYTES);
    localparam int         AIW       = $clog2(ALM_BYTES);
    localparam logic [7:0] ALM_END   = 8'(ALM_BYTES);
    localparam logic [7:0] TIME_END  = 8'(TIME_BASE + BLK_BYTES);

    logic [7:0] time_q  [BLK_BYTES];
    logic [7:0] alarm_q [ALM_BYTES];
    logic [2:0] dtrim_q;
    logic [5:0] atrim_q;

    logic [7:0] w_off, r_off;
    logic       w_alm_hit, r_alm_hit, r_time_hit;

    always_comb begin
        w_off      = waddr - TIME_BASE;
        r_off      = raddr - TIME_BASE;
        w_time_hit = (waddr >= TIME_BASE) && (waddr < TIME_END);
        r_time_hit = (raddr >= TIME_BASE) && (raddr < TIME_END);
        w_alm_hit  = (waddr < ALM_END);
        r_alm_hit  = (raddr < ALM_END);
        w_idx      = w_off[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLK_BYTES; i++) time_q[i]  <= '0;
            for (int i = 0; i < ALM_BYTES; i++) alarm_q[i] <= '0;
            dtrim_q <= '0;
            atrim_q <= '0;
        end else if (wr_en) begin
            if (w_time_hit)                time_q[w_off[IW-1:0]]   <= wdata;
            else if (w_alm_hit)            alarm_q[waddr[AIW-1:0]] <= wdata;
            else if (waddr == DTRIM_ADDR)  dtrim_q <= wdata[2:0];
            else if (waddr == ATRIM_ADDR)  atrim_q <= wdata[5:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (r_time_hit)                rdata = time_q[r_off[IW-1:0]];
        else if (r_alm_hit)            rdata = alarm_q[raddr[AIW-1:0]];
        else if (raddr == DTRIM_ADDR)  rdata = {5'b0, dtrim_q};
        else if (raddr == ATRIM_ADDR)  rdata = {2'b0, atrim_q};
    end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import wpr_pkg::*;
#(
    parameter int BLK_BYTES  = 8,
    parameter int ALARM_SETS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ptr_set_i,
    input  logic [7:0]                   ptr_hi_i,
    input  logic [7:0]                   ptr_lo_i,
    input  logic                         wr_en_i,
    input  logic [7:0]                   wr_data_i,
    input  logic                         rd_en_i,
    output logic [7:0]                   rd_data_o,
    output logic                         load_o,
    output logic [$clog2(BLK_BYTES)-1:0] load_idx_o,
    output logic [7:0]                   load_byte_o
);
    localparam int IW = $clog2(BLK_BYTES);

    logic [15:0]   ptr_q;
    logic          mapped, st_wr, prot_wr, time_wr, rtcf_q, wel, rwel, w_time_hit;
    logic [7:0]    reg_addr, store_rdata;
    logic [IW-1:0] w_idx;
    lock_e         lock_st;

    always_comb begin
        mapped   = (ptr_q[15:8] == 8'h00);
        reg_addr = ptr_q[7:0];
        st_wr    = wr_en_i && mapped && (reg_addr == STATUS_ADDR);
        prot_wr  = wr_en_i && mapped && rwel && (reg_addr != STATUS_ADDR);
        time_wr  = prot_wr && w_time_hit;
    end

    wpr_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_wr   (st_wr),
        .st_data (wr_data_i),
        .state   (lock_st),
        .wel     (wel),
        .rwel    (rwel)
    );

    wpr_reg_store #(
        .BLK_BYTES  (BLK_BYTES),
        .ALARM_SETS (ALARM_SETS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (prot_wr),
        .waddr      (reg_addr),
        .wdata      (wr_data_i),
        .raddr      (reg_addr),
        .rdata      (store_rdata),
        .w_time_hit (w_time_hit),
        .w_idx      (w_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            rd_data_o   <= '0;
            rtcf_q      <= 1'b1;
            load_o      <= 1'b0;
            load_idx_o  <= '0;
            load_byte_o <= '0;
        end else begin
            if (ptr_set_i)    ptr_q <= {ptr_hi_i, ptr_lo_i};
            else if (rd_en_i) ptr_q <= ptr_q + 16'd1;

            if (rd_en_i) begin
                if (!mapped)                        rd_data_o <= '0;
                else if (reg_addr == STATUS_ADDR)   rd_data_o <= {5'b0, rwel, wel, rtcf_q};
                else                                rd_data_o <= store_rdata;
            end

            if (time_wr) rtcf_q <= 1'b0;

            load_o <= time_wr;
            if (time_wr) begin
                load_idx_o  <= w_idx;
                load_byte_o <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
    import wpr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en_i,
    input logic        ptr_set_i,
    input logic [15:0] ptr_q,
    input lock_e       lock_st,
    input logic        rtcf_q,
    input logic        load_o,
    input logic        st_wr,
    input logic [7:0]  wr_data_i
);
    AST_LOAD_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(lock_st) == LK_OPEN); // R3

    AST_OPEN_VIA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_st == LK_OPEN && $past(lock_st) != LK_OPEN) |-> $past(lock_st) == LK_LATCH); // R4

    AST_RELOCK_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wr_data_i == 8'h00) |=> lock_st == LK_LOCKED); // R5

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !ptr_set_i) |=> ptr_q == $past(ptr_q) + 16'd1); // R6

    AST_FAIL_CLEAR_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rtcf_q) |-> load_o); // R9

    AST_FAIL_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rtcf_q |=> !rtcf_q); // R9
endmodule

bind rtc_regbank rtc_regbank_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .ptr_set_i (ptr_set_i),
    .ptr_q     (ptr_q),
    .lock_st   (lock_st),
    .rtcf_q    (rtcf_q),
    .load_o    (load_o),
    .st_wr     (st_wr),
    .wr_data_i (wr_data_i)
);

// File: tb/rtc_regbank_tb_top.sv
module rtc_regbank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptr_set = 1'b0;
    logic [7:0] ptr_hi = '0, ptr_lo = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdat = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdat;
    logic       load;
    logic [2:0] load_idx;
    logic [7:0] load_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       ld1, ld2;
    logic [2:0] ldi;
    logic [7:0] ldb;

    always #2 clk = ~clk;

    rtc_regbank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_set_i   (ptr_set),
        .ptr_hi_i    (ptr_hi),
        .ptr_lo_i    (ptr_lo),
        .wr_en_i     (wr_en),
        .wr_data_i   (wdat),
        .rd_en_i     (rd_en),
        .rd_data_o   (rdat),
        .load_o      (load),
        .load_idx_o  (load_idx),
        .load_byte_o (load_byte)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); ptr_set = 1'b1; ptr_hi = a[15:8]; ptr_lo = a[7:0];
        @(negedge clk); ptr_set = 1'b0; wr_en = 1'b1; wdat = d;
        @(negedge clk); wr_en = 1'b0; ld1 = load; ldi = load_idx; ldb = load_byte;
        @(negedge clk); ld2 = load;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk); ptr_set = 1'b1; ptr_hi = a[15:8]; ptr_lo = a[7:0];
        @(negedge clk); ptr_set = 1'b0; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rdat;
    endtask

    task automatic unlock();
        wr(16'h003F, 8'h02);
        wr(16'h003F, 8'h06);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(16'h003F, v); chk("R1 status after reset", v, 8'h01);
        rd(16'h0030, v); chk("R1 seconds after reset", v, 8'h00);
        rd(16'h0008, v); chk("R1 alarm1 after reset", v, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        wr(16'h0030, 8'h45);
        chk("R10 no load when locked", {7'b0, ld1}, 8'h00);
        rd(16'h0030, v); chk("R3 locked time write ignored", v, 8'h00);
        wr(16'h0013, 8'h05);
        rd(16'h0013, v); chk("R3 locked trim write ignored", v, 8'h00);
    endtask

    task automatic t_skip_latch();
        logic [7:0] v;
        wr(16'h003F, 8'h06);
        rd(16'h003F, v); chk("R4 status after bare 0x06", v, 8'h01);
        wr(16'h0031, 8'h12);
        rd(16'h0031, v); chk("R4 write after bare 0x06 ignored", v, 8'h00);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        wr(16'h003F, 8'h02);
        rd(16'h003F, v); chk("R2 status after 0x02", v, 8'h03);
        wr(16'h003F, 8'h06);
        rd(16'h003F, v); chk("R2 status after 0x06", v, 8'h07);
    endtask

    task automatic t_alarm();
        logic [7:0] v;
        wr(16'h0000, 8'h11);
        chk("R10 no load on alarm write", {7'b0, ld1}, 8'h00);
        rd(16'h003F, v); chk("R9 alarm write keeps failure flag", v, 8'h07);
        wr(16'h0008, 8'h22);
        wr(16'h000F, 8'h20);
        rd(16'h0000, v); chk("R11 alarm0 byte0", v, 8'h11);
        rd(16'h0008, v); chk("R11 alarm1 byte0", v, 8'h22);
        rd(16'h000F, v); chk("R11 alarm1 byte7", v, 8'h20);
        rd(16'h0007, v); chk("R11 alarm0 byte7 untouched", v, 8'h00);
    endtask

    task automatic t_time();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            wr(16'h0030 + 16'(i), 8'h20 + 8'(i));
            if (i == 0) begin
                chk("R10 load pulse", {7'b0, ld1}, 8'h01);
                chk("R10 load index", {5'b0, ldi}, 8'h00);
                chk("R10 load byte", ldb, 8'h20);
                chk("R10 pulse lasts one cycle", {7'b0, ld2}, 8'h00);
                rd(16'h003F, v); chk("R9 time write clears failure flag", v, 8'h06);
            end
            if (i == 5) begin
                chk("R10 load index 5", {5'b0, ldi}, 8'h05);
                chk("R10 load byte 5", ldb, 8'h25);
            end
        end
    endtask

    task automatic t_burst();
        @(negedge clk); ptr_set = 1'b1; ptr_hi = 8'h00; ptr_lo = 8'h30;
        @(negedge clk); ptr_set = 1'b0; rd_en = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (i == 8) begin
                rd_en = 1'b0;
                chk("R7 byte after time block reads zero", rdat, 8'h00);
            end else begin
                chk($sformatf("R6 burst byte %0d", i), rdat, 8'h20 + 8'(i));
            end
        end
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(16'h0013, 8'hFF);
        rd(16'h0013, v); chk("R8 digital trim upper bits zero", v, 8'h07);
        wr(16'h0012, 8'hFF);
        rd(16'h0012, v); chk("R8 analog trim upper bits zero", v, 8'h3F);
        wr(16'h0010, 8'hFF);
        rd(16'h0010, v); chk("R8 register 0x10 zero", v, 8'h00);
        wr(16'h003F, 8'h1E);
        rd(16'h003F, v); chk("R5 other value relocks, R8 status bits zero", v, 8'h00);
        wr(16'h0012, 8'h01);
        rd(16'h0012, v); chk("R5 write after other value ignored", v, 8'h3F);
    endtask

    task automatic t_relock();
        logic [7:0] v;
        unlock();
        wr(16'h003F, 8'h00);
        rd(16'h003F, v); chk("R5 status after 0x00", v, 8'h00);
        wr(16'h0030, 8'h77);
        chk("R5 no load after relock", {7'b0, ld1}, 8'h00);
        rd(16'h0030, v); chk("R5 time unchanged after relock", v, 8'h20);
    endtask

    task automatic t_hi_addr();
        logic [7:0] v;
        unlock();
        wr(16'h0130, 8'h55);
        chk("R7 no load for high address", {7'b0, ld1}, 8'h00);
        rd(16'h0030, v); chk("R7 high address write no alias", v, 8'h20);
        rd(16'h0130, v); chk("R7 high address reads zero", v, 8'h00);
        rd(16'h0020, v); chk("R7 unmapped reads zero", v, 8'h00);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_skip_latch();
        t_unlock();
        t_alarm();
        t_time();
        t_burst();
        t_reserved();
        t_relock();
        t_hi_addr();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule